// File: doc/BRIEF.md
# Multi-width card data block framer

This block frames and unframes data blocks on the data lines of a memory-card style bus. The bus runs on 1, 4 or 8 lines. On the transmit side, bytes arrive from a valid/ready stream and leave as a start bit, the payload, a CRC-16 per line and an end bit. On the receive side, the block waits for a start bit, collects the payload bytes, checks every line's CRC and end bit, and reports one error flag per block.

After each transmitted block the line drivers are released and the block reports the card as busy for as long as the card holds the first data line low. A new block can start only after that. The command line, clock generation, card set-up and pad timing live elsewhere. The block drives only per-line data values and per-line output enables.

Top module: `card_data_framer`

## Requirements
- R1: While reset is held and right after it, dat_oe and dat_out are all zero, and busy, tx_ready, rx_valid, rx_done and crc_error are low.
- R2: width_sel encodes the line count: 1 selects DAT3..DAT0, 2 selects DAT7..DAT0 (when WIDE8_EN is nonzero, otherwise one line), and 0 or 3 select DAT0 alone. The transmitter samples width_sel and blk_len on tx_start. The receiver samples them at the start bit.
- R3: dat_oe is set on exactly the active lines from the start bit through the end bit and is zero at all other times. dat_out is 0 on every line that is not carrying a frame bit.
- R4: A transmitted block begins with exactly one cycle in which every active line drives 0.
- R5: Payload bytes go out most significant bit first. On 1 line each byte takes 8 cycles on DAT0. On 4 lines bits 7..4 go out first on DAT3..DAT0, followed by bits 3..0. On 8 lines bit n goes out on DATn in a single cycle.
- R6: After the payload, each active line sends for 16 cycles its own CRC, most significant bit first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), starts at zero, and covers only the payload bits on that line.
- R7: One cycle with every active line at 1 follows the CRC. The drivers are then released.
- R8: busy rises the cycle after the end bit. For the first BUSY_GAP cycles it stays high whatever the lines show. After that it drops on the first cycle in which DAT0 is 1. The other data lines have no effect on it.
- R9: tx_ready is high only inside a frame, and exactly blk_len bytes are accepted per block. tx_start has no effect while a block or its busy period is in progress.
- R10: The receiver ignores every cycle in which rx_en is low or DAT0 is 1. It treats the first cycle with rx_en high and DAT0 low as the start bit.
- R11: Each received byte is delivered as a one-cycle rx_valid pulse with rx_data, using the same bit-to-line order as R5. Exactly blk_len bytes are delivered per block.
- R12: rx_done pulses for one cycle after the end bit. At the same time crc_error is set if any active line's CRC mismatched or any active line's end bit was 0. crc_error holds that value until the next rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Line count selection |
| blk_len | input | LEN_W | Block length in bytes, 1 to 512 |
| tx_start | input | 1 | Begin a transmit block |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte present |
| tx_ready | output | 1 | Transmit byte taken on this edge |
| dat_out | output | 8 | Data line drive values |
| dat_oe | output | 8 | Per-line output enables |
| dat_in | input | 8 | Sampled data line levels |
| busy | output | 1 | Card busy after a transmitted block |
| rx_en | input | 1 | Receiver enable |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_done | output | 1 | Receive block complete |
| crc_error | output | 1 | Last received block failed CRC or end-bit check |

## Verification
The embedded properties check on every cycle that an enabled frame opens with all lines low and closes with the enabled lines high. They also check that busy cannot fall while DAT0 is low, that rx_done never lasts two cycles, and that crc_error moves only together with rx_done. Whether the payload order per line, the CRC values, the byte count and the error verdict are correct for each width can only be shown by the bench. It builds every frame from the payload on its own and compares it line by line, including corrupted CRC bits, a zero end bit, a maximum-length block and DAT0 activity while the receiver is disabled.

// File: rtl/card_data_framer.sv
module card_data_framer #(
  parameter int WIDE8_EN = 1,
  parameter int LEN_W    = 10,
  parameter int BUSY_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       width_sel,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             tx_start,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       dat_out,
  output logic [7:0]       dat_oe,
  input  logic [7:0]       dat_in,
  output logic             busy,
  input  logic             rx_en,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_done,
  output logic             crc_error
);
  localparam int GAP_W = $clog2(BUSY_GAP + 2);

  function automatic logic [3:0] lanes_of(input logic [1:0] w);
    if (w == 2'd1) return 4'd4;
    if (w == 2'd2 && WIDE8_EN != 0) return 4'd8;
    return 4'd1;
  endfunction

  function automatic logic [7:0] mask_of(input logic [3:0] n);
    logic [8:0] t;
    t = (9'd1 << n) - 9'd1;
    return t[7:0];
  endfunction

  function automatic logic [2:0] last_beat_of(input logic [3:0] n);
    if (n == 4'd8) return 3'd0;
    if (n == 4'd4) return 3'd1;
    return 3'd7;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  typedef enum logic [2:0] {T_IDLE, T_ARM, T_START, T_DATA, T_CRC, T_END, T_WATCH} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_DATA, R_CRC, R_END} rx_st_t;

  tx_st_t           tst;
  logic [3:0]       t_lanes;
  logic [LEN_W-1:0] t_len, t_acc, t_sent;
  logic [2:0]       t_beat;
  logic [3:0]       t_cnt;
  logic [7:0]       t_sh, hd;
  logic             hd_full;
  logic [15:0]      tcrc [8];
  logic [GAP_W-1:0] gap;

  logic [7:0] t_mask, tx_bits, crc_top;
  logic       t_last, t_more, take, adv, accept;

  assign t_mask  = mask_of(t_lanes);
  assign t_last  = (t_beat == last_beat_of(t_lanes));
  assign t_more  = (t_sent != t_len - LEN_W'(1));
  assign take    = (tst == T_START) || (tst == T_DATA && t_last && t_more && hd_full);
  assign adv     = (tst == T_DATA) && !(t_last && t_more && !hd_full);
  assign tx_bits = (t_sh >> (4'd8 - t_lanes)) & t_mask;
  assign tx_ready = (tst == T_ARM || tst == T_START || tst == T_DATA)
                    && (!hd_full || take) && (t_acc != t_len);
  assign accept  = tx_valid && tx_ready;
  assign busy    = (tst == T_WATCH);
  assign dat_oe  = (tst == T_START || tst == T_DATA || tst == T_CRC || tst == T_END) ? t_mask : 8'h00;

  always_comb begin
    for (int i = 0; i < 8; i++) crc_top[i] = tcrc[i][15];
    crc_top = crc_top & t_mask;
    case (tst)
      T_DATA:  dat_out = tx_bits;
      T_CRC:   dat_out = crc_top;
      T_END:   dat_out = t_mask;
      default: dat_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst     <= T_IDLE;
      t_lanes <= 4'd1;
      t_len   <= '0;
      t_acc   <= '0;
      t_sent  <= '0;
      t_beat  <= '0;
      t_cnt   <= '0;
      t_sh    <= '0;
      hd      <= '0;
      hd_full <= 1'b0;
      gap     <= '0;
      for (int i = 0; i < 8; i++) tcrc[i] <= '0;
    end else begin
      if (accept) begin
        hd      <= tx_data;
        hd_full <= 1'b1;
        t_acc   <= t_acc + LEN_W'(1);
      end else if (take) begin
        hd_full <= 1'b0;
      end
      case (tst)
        T_IDLE: if (tx_start) begin
          t_lanes <= lanes_of(width_sel);
          t_len   <= blk_len;
          t_acc   <= '0;
          t_sent  <= '0;
          tst     <= T_ARM;
        end
        T_ARM: if (hd_full) tst <= T_START;
        T_START: begin
          t_sh   <= hd;
          t_beat <= '0;
          for (int i = 0; i < 8; i++) tcrc[i] <= '0;
          tst    <= T_DATA;
        end
        T_DATA: if (adv) begin
          for (int i = 0; i < 8; i++)
            if (i < int'(t_lanes)) tcrc[i] <= crc_step(tcrc[i], tx_bits[i]);
          if (t_last) begin
            if (t_more) begin
              t_sh   <= hd;
              t_beat <= '0;
              t_sent <= t_sent + LEN_W'(1);
            end else begin
              t_cnt <= '0;
              tst   <= T_CRC;
            end
          end else begin
            t_sh   <= t_sh << t_lanes;
            t_beat <= t_beat + 3'd1;
          end
        end
        T_CRC: begin
          for (int i = 0; i < 8; i++) tcrc[i] <= {tcrc[i][14:0], 1'b0};
          t_cnt <= t_cnt + 4'd1;
          if (t_cnt == 4'd15) tst <= T_END;
        end
        T_END: begin
          gap <= '0;
          tst <= T_WATCH;
        end
        T_WATCH: begin
          if (gap != GAP_W'(BUSY_GAP)) gap <= gap + GAP_W'(1);
          else if (dat_in[0]) tst <= T_IDLE;
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

  rx_st_t           rst_q;
  logic [3:0]       r_lanes;
  logic [LEN_W-1:0] r_len, r_cnt;
  logic [2:0]       r_beat;
  logic [3:0]       r_ccnt;
  logic [7:0]       r_sh;
  logic [15:0]      rcrc [8];

  logic [7:0] r_mask, r_sh_n;
  logic       r_bad;

  assign r_mask = mask_of(r_lanes);
  assign r_sh_n = (r_sh << r_lanes) | (dat_in & r_mask);

  always_comb begin
    r_bad = ((dat_in & r_mask) != r_mask);
    for (int i = 0; i < 8; i++)
      if (i < int'(r_lanes) && rcrc[i] != 16'h0000) r_bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q     <= R_IDLE;
      r_lanes   <= 4'd1;
      r_len     <= '0;
      r_cnt     <= '0;
      r_beat    <= '0;
      r_ccnt    <= '0;
      r_sh      <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_done   <= 1'b0;
      crc_error <= 1'b0;
      for (int i = 0; i < 8; i++) rcrc[i] <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_done  <= 1'b0;
      if (!rx_en) begin
        rst_q <= R_IDLE;
      end else begin
        case (rst_q)
          R_IDLE: if (!dat_in[0]) begin
            r_lanes <= lanes_of(width_sel);
            r_len   <= blk_len;
            r_cnt   <= '0;
            r_beat  <= '0;
            for (int i = 0; i < 8; i++) rcrc[i] <= '0;
            rst_q   <= R_DATA;
          end
          R_DATA: begin
            for (int i = 0; i < 8; i++)
              if (i < int'(r_lanes)) rcrc[i] <= crc_step(rcrc[i], dat_in[i]);
            r_sh <= r_sh_n;
            if (r_beat == last_beat_of(r_lanes)) begin
              rx_data  <= r_sh_n;
              rx_valid <= 1'b1;
              r_beat   <= '0;
              r_cnt    <= r_cnt + LEN_W'(1);
              if (r_cnt == r_len - LEN_W'(1)) begin
                r_ccnt <= '0;
                rst_q  <= R_CRC;
              end
            end else begin
              r_beat <= r_beat + 3'd1;
            end
          end
          R_CRC: begin
            for (int i = 0; i < 8; i++)
              if (i < int'(r_lanes)) rcrc[i] <= crc_step(rcrc[i], dat_in[i]);
            r_ccnt <= r_ccnt + 4'd1;
            if (r_ccnt == 4'd15) rst_q <= R_END;
          end
          R_END: begin
            rx_done   <= 1'b1;
            crc_error <= r_bad;
            rst_q     <= R_IDLE;
          end
          default: rst_q <= R_IDLE;
        endcase
      end
    end
  end

  // R4
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe[0]) |-> dat_out == 8'h00);

  // R7
  end_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe[0]) |-> $past(dat_out) == $past(dat_oe));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dat_in[0]) |=> busy);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R12
  verdict_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_error) |-> rx_done);

  // R9
  no_ready_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);
endmodule

// File: tb/tb_card_data_framer.sv
module tb_card_data_framer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] width_sel;
  logic [9:0] blk_len;
  logic       tx_start, tx_valid, tx_ready;
  logic [7:0] tx_data, dat_out, dat_oe, dat_in, rx_data;
  logic       busy, rx_en, rx_valid, rx_done, crc_error;

  always #2 clk = ~clk;

  card_data_framer dut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .blk_len(blk_len),
    .tx_start(tx_start), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in), .busy(busy),
    .rx_en(rx_en), .rx_data(rx_data), .rx_valid(rx_valid), .rx_done(rx_done),
    .crc_error(crc_error)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  logic [7:0]  pay [0:512];
  logic [15:0] ecrc [0:7];
  int          tx_idx = 0;
  bit          acc_pend = 1'b0;

  always @(negedge clk) begin
    if (acc_pend) tx_idx = tx_idx + 1;
    acc_pend = tx_ready && tx_valid;
    tx_data  = pay[(tx_idx > 512) ? 512 : tx_idx];
  end

  function automatic int lanes_for(input int w);
    if (w == 1) return 4;
    if (w == 2) return 8;
    return 1;
  endfunction

  function automatic logic [7:0] lane_mask(input int n);
    return (n == 8) ? 8'hFF : ((n == 4) ? 8'h0F : 8'h01);
  endfunction

  function automatic logic [7:0] beat_bits(input int n, input int k, input int j);
    logic [7:0] b = 8'h00;
    for (int l = 0; l < n; l++) b[l] = pay[k][8 - (j + 1) * n + l];
    return b;
  endfunction

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b);
    logic fb = c[15] ^ b;
    logic [15:0] r = c << 1;
    if (fb) r = r ^ 16'h1021;
    return r;
  endfunction

  task automatic prep(input int seed, input int len, input int n);
    for (int k = 0; k < 513; k++) pay[k] = 8'(seed + k * 37);
    for (int l = 0; l < 8; l++) ecrc[l] = 16'h0000;
    for (int k = 0; k < len; k++)
      for (int j = 0; j < 8 / n; j++) begin
        logic [7:0] bb = beat_bits(n, k, j);
        for (int l = 0; l < n; l++) ecrc[l] = crc_next(ecrc[l], bb[l]);
      end
  endtask

  function automatic logic [7:0] frame_val(input int n, input int len, input int c);
    int nb = 8 / n;
    logic [7:0] v = 8'h00;
    if (c == 0) return 8'h00;
    if (c <= len * nb) return beat_bits(n, (c - 1) / nb, (c - 1) % nb);
    if (c <= len * nb + 16) begin
      for (int l = 0; l < n; l++) v[l] = ecrc[l][15 - (c - 1 - len * nb)];
      return v;
    end
    return lane_mask(n);
  endfunction

  task automatic run_tx(input int w, input int len, input int bmode);
    int n = lanes_for(w);
    int total = 1 + len * (8 / n) + 16 + 1;
    int bad_oe = 0, bad_st = 0, bad_pl = 0, bad_crc = 0, bad_end = 0;
    logic [7:0] first_act = 0, first_exp = 0;
    int nbusy;
    @(negedge clk);
    width_sel = 2'(w); blk_len = 10'(len); tx_idx = 0; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int g = 0; g < 10 && dat_oe == 8'h00; g++) @(negedge clk);
    for (int c = 0; c < total; c++) begin
      logic [7:0] e = frame_val(n, len, c);
      if (dat_oe != lane_mask(n)) bad_oe++;
      if (dat_out != e) begin
        if (bad_st + bad_pl + bad_crc + bad_end == 0) begin first_act = dat_out; first_exp = e; end
        if (c == 0) bad_st++;
        else if (c <= len * (8 / n)) bad_pl++;
        else if (c < total - 1) bad_crc++;
        else bad_end++;
      end
      @(negedge clk);
    end
    chk(bad_oe == 0, "R3", "enable cycles off the active mask", bad_oe, 0);
    chk(bad_oe == 0, "R2", "active line mask for width", dat_oe, lane_mask(n));
    chk(bad_st == 0, "R4", "start bit", first_act, first_exp);
    chk(bad_pl == 0, "R5", "payload beats", first_act, first_exp);
    chk(bad_crc == 0, "R6", "per-line CRC", first_act, first_exp);
    chk(bad_end == 0, "R7", "end bit", first_act, first_exp);
    chk(tx_idx == len, "R9", "bytes accepted", tx_idx, len);
    chk(busy == 1'b1 && dat_oe == 8'h00 && dat_out == 8'h00, "R8", "busy after end, lines released",
        {busy, dat_oe, dat_out}, 32'h10000);
    if (bmode == 0) begin
      nbusy = 0;
      dat_in = 8'h00;
      for (int i = 0; i < 4; i++) begin
        tx_start = (i == 1);
        @(negedge clk);
        if (busy) nbusy++;
      end
      tx_start = 1'b0;
      chk(nbusy == 4, "R8", "busy held while DAT0 low", nbusy, 4);
      dat_in = 8'h01;
      @(negedge clk);
      chk(busy == 1'b0, "R8", "release on DAT0 only", busy, 0);
      dat_in = 8'hFF;
      nbusy = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (dat_oe != 8'h00 || tx_ready) nbusy++;
      end
      chk(nbusy == 0, "R9", "tx_start during busy ignored", nbusy, 0);
    end else begin
      nbusy = 0;
      for (int i = 0; i < 8; i++) begin
        if (busy) nbusy++;
        @(negedge clk);
      end
      chk(nbusy == 3, "R8", "busy cycles with DAT0 high from start", nbusy, 3);
    end
  endtask

  int rk, rbad, rdones;
  logic rerr;
  logic [7:0] rfirst_act, rfirst_exp;

  task automatic rx_sample();
    if (rx_valid) begin
      if (rx_data != pay[(rk > 512) ? 512 : rk]) begin
        if (rbad == 0) begin rfirst_act = rx_data; rfirst_exp = pay[(rk > 512) ? 512 : rk]; end
        rbad++;
      end
      rk++;
    end
    if (rx_done) begin
      rdones++;
      rerr = crc_error;
    end
  endtask

  task automatic run_rx(input int w, input int len, input int corrupt, input bit exp_err);
    int n = lanes_for(w);
    int total = 1 + len * (8 / n) + 16 + 1;
    logic [7:0] m = lane_mask(n);
    rk = 0; rbad = 0; rdones = 0; rerr = 1'b0; rfirst_act = 0; rfirst_exp = 0;
    @(negedge clk);
    rx_en = 1'b1; width_sel = 2'(w); blk_len = 10'(len); dat_in = 8'hFF;
    for (int i = 0; i < 3; i++) begin @(negedge clk); rx_sample(); end
    chk(rk == 0 && rdones == 0, "R10", "idle cycles with DAT0 high", rk + rdones, 0);
    for (int c = 0; c < total; c++) begin
      logic [7:0] v = frame_val(n, len, c) | ~m;
      if (corrupt == 1 && c == len * (8 / n) + 6) v[n - 1] = ~v[n - 1];
      if (corrupt == 2 && c == total - 1) v[n - 1] = 1'b0;
      @(negedge clk);
      rx_sample();
      dat_in = v;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_sample();
      dat_in = 8'hFF;
    end
    chk(rk == len, "R11", "bytes delivered", rk, len);
    chk(rbad == 0, "R11", "received byte value", rfirst_act, rfirst_exp);
    chk(rdones == 1, "R12", "rx_done pulses", rdones, 1);
    chk(rerr == exp_err, "R12", "crc_error verdict", rerr, exp_err);
    chk(crc_error == exp_err, "R12", "crc_error held", crc_error, exp_err);
    rx_en = 1'b0;
  endtask

  // fields: [31:30] width_sel, [29:28] corruption (0 none, 1 CRC bit, 2 end bit),
  // [27] busy mode, [26] expected crc_error, [25:16] length, [7:0] seed
  localparam logic [31:0] VEC [8] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 10'd1,   8'h00, 8'hA5},
    {2'd1, 2'd0, 1'b1, 1'b0, 10'd3,   8'h00, 8'h3C},
    {2'd2, 2'd1, 1'b0, 1'b1, 10'd4,   8'h00, 8'h71},
    {2'd3, 2'd2, 1'b0, 1'b1, 10'd2,   8'h00, 8'h0F},
    {2'd1, 2'd1, 1'b1, 1'b1, 10'd5,   8'h00, 8'hE2},
    {2'd2, 2'd2, 1'b0, 1'b1, 10'd1,   8'h00, 8'h99},
    {2'd0, 2'd1, 1'b1, 1'b1, 10'd2,   8'h00, 8'h5A},
    {2'd1, 2'd0, 1'b0, 1'b0, 10'd512, 8'h00, 8'h12}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; width_sel = 2'd0; blk_len = 10'd1; tx_start = 1'b0; tx_valid = 1'b1;
    dat_in = 8'hFF; rx_en = 1'b0;
    for (int k = 0; k < 513; k++) pay[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk(dat_oe == 0 && dat_out == 0, "R1", "lines during reset", {dat_oe, dat_out}, 0);
    chk(!busy && !tx_ready && !rx_valid && !rx_done && !crc_error, "R1", "flags during reset",
        {busy, tx_ready, rx_valid, rx_done, crc_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dat_oe == 0 && dat_out == 0 && !busy && !tx_ready && !rx_done && !crc_error, "R1",
        "state after reset", {dat_oe, dat_out, busy, tx_ready, rx_done, crc_error}, 0);

    for (int v = 0; v < 8; v++) begin
      int w   = int'(VEC[v][31:30]);
      int len = int'(VEC[v][25:16]);
      prep(int'(VEC[v][7:0]), len, lanes_for(w));
      run_tx(w, len, int'(VEC[v][27]));
      run_rx(w, len, int'(VEC[v][29:28]), VEC[v][26]);
    end

    rk = 0; rdones = 0; rbad = 0;
    rx_en = 1'b0; dat_in = 8'h00;
    for (int i = 0; i < 6; i++) begin @(negedge clk); rx_sample(); end
    chk(rk == 0 && rdones == 0, "R10", "DAT0 low with receiver disabled", rk + rdones, 0);
    dat_in = 8'hFF;
    prep(8'h44, 3, 1);
    run_rx(0, 3, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule